// File: doc/BRIEF.md
# Inter-processor mailbox bank

A bank of sixteen 32-bit mailboxes, organised as four mailboxes for each of four cores, that one core uses to signal another. A sender writes a word to a mailbox's set address and every 1 in that word is ORed into the mailbox. The receiver reads the mailbox, picks a bit such as the lowest one that is set, and acknowledges it by writing that bit to the mailbox's clear address. Because each mailbox holds 32 independent bits, one mailbox carries up to 32 distinct message codes. It can also carry a full 32-bit value, such as the start address handed to a secondary core, when that value is written into an empty mailbox.

Two independent write channels (A and B) reach the bank, so two agents can update the same mailbox in one cycle. When set and clear hits on one mailbox coincide, the clears win over the sets. One read channel returns a mailbox's contents one cycle after the request. For every mailbox the block drives a registered level summary that is high while any bit of that mailbox is 1. A separate per-core router consumes these summaries.

Top module: `ipc_mailbox_bank`

## Requirements
- R1: In the cycle after synchronous reset is released, every mailbox reads 0, `mbox_pending` is all zeros and `rd_valid` is low.
- R2: A write to address 0x080 + 16·c + 4·m (the set window) ORs the write data into mailbox m of core c, which is mailbox index 4·c + m.
- R3: A write to address 0x0C0 + 16·c + 4·m (the clear window) clears exactly those bits of mailbox 4·c + m where the write data is 1, and leaves the other bits unchanged.
- R4: A read request at either window address of a mailbox raises `rd_valid` for one cycle on the next clock edge, with `rd_data` holding the contents the mailbox had before any write accepted on the same edge as the request.
- R5: Bit 4·c + m of `mbox_pending` is 1 exactly when mailbox 4·c + m is nonzero. It changes on the same clock edge as the mailbox contents.
- R6: When both write channels hit one mailbox in the same cycle, its new value is (old OR all set data) AND NOT (all clear data). Two sets therefore combine by OR, and a clear wins over a coincident set on the same bit.
- R7: A write whose address lies outside both windows, or whose two low address bits are not 00, changes no mailbox. A read of such an address returns 0 with `rd_valid` high.
- R8: A 32-bit value written to the set address of an empty mailbox reads back unchanged. A receiver can then clear the lowest set bit of a message word, one bit at a time, until the mailbox is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wa_en | input | 1 | Write channel A strobe |
| wa_addr | input | 8 | Write channel A byte address |
| wa_data | input | 32 | Write channel A data |
| wb_en | input | 1 | Write channel B strobe |
| wb_addr | input | 8 | Write channel B byte address |
| wb_data | input | 32 | Write channel B data |
| rd_en | input | 1 | Read request strobe |
| rd_addr | input | 8 | Read byte address (either window) |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | High for one cycle when `rd_data` holds a result |
| mbox_pending | output | 16 | Per-mailbox nonzero summary, bit 4·c + m |

## Verification
A mailbox holding a wrong bit shows up in two places. The matching `mbox_pending` bit is wrong on the next clock edge whenever that mailbox's emptiness changes. The bit itself appears in `rd_data` one cycle after any read of that mailbox. The bench therefore compares the whole summary vector with a model after every cycle, and sweeps reads across all sixteen mailboxes after each phase. This catches a stray write into the wrong mailbox within one sweep, even when the summary does not change. The same-cycle set/clear collision, the read that races a write, and writes to stray or misaligned addresses are each driven explicitly, because a decode or ordering fault stays invisible under ordinary traffic.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2
  } mbox_op_e;

  localparam int unsigned BYTES_PER_WORD = 4;

endpackage

// File: rtl/ipc_mbox_decode.sv
module ipc_mbox_decode
  import ipc_mbox_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned N_MBOX   = 16,
  parameter int unsigned SET_BASE = 'h80,
  parameter int unsigned CLR_BASE = 'hC0,
  parameter int unsigned IDX_W    = $clog2(N_MBOX)
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output mbox_op_e          op,
  output logic [IDX_W-1:0]  idx
);

  localparam int unsigned SPAN = N_MBOX * BYTES_PER_WORD;
  localparam logic [ADDR_W:0] SET_LO = (ADDR_W+1)'(SET_BASE);
  localparam logic [ADDR_W:0] SET_HI = (ADDR_W+1)'(SET_BASE + SPAN);
  localparam logic [ADDR_W:0] CLR_LO = (ADDR_W+1)'(CLR_BASE);
  localparam logic [ADDR_W:0] CLR_HI = (ADDR_W+1)'(CLR_BASE + SPAN);

  logic [ADDR_W:0] addr_x;
  logic [ADDR_W:0] offset;
  logic            aligned;
  logic            in_set;
  logic            in_clr;

  always_comb begin
    addr_x  = {1'b0, addr};
    aligned = (addr[1:0] == 2'b00);
    in_set  = (addr_x >= SET_LO) && (addr_x < SET_HI);
    in_clr  = (addr_x >= CLR_LO) && (addr_x < CLR_HI);
    op      = OP_NONE;
    offset  = '0;
    if (en && aligned) begin
      if (in_set) begin
        op     = OP_SET;
        offset = addr_x - SET_LO;
      end else if (in_clr) begin
        op     = OP_CLR;
        offset = addr_x - CLR_LO;
      end
    end
    idx = IDX_W'(offset >> 2);
  end

endmodule

// File: rtl/ipc_mbox_cell.sv
module ipc_mbox_cell #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] set_mask,
  input  logic [DATA_W-1:0] clr_mask,
  output logic [DATA_W-1:0] value,
  output logic              pending
);

  logic [DATA_W-1:0] value_q;
  logic [DATA_W-1:0] value_nxt;
  logic              pending_q;

  // clears are applied after sets
  always_comb begin
    value_nxt = (value_q | set_mask) & ~clr_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      value_q   <= '0;
      pending_q <= 1'b0;
    end else begin
      value_q   <= value_nxt;
      pending_q <= |value_nxt;
    end
  end

  assign value   = value_q;
  assign pending = pending_q;

endmodule

// File: rtl/ipc_mbox_rdport.sv
module ipc_mbox_rdport
  import ipc_mbox_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_MBOX = 16,
  parameter int unsigned IDX_W  = $clog2(N_MBOX)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_en,
  input  mbox_op_e                 rd_op,
  input  logic [IDX_W-1:0]         rd_idx,
  input  logic [N_MBOX*DATA_W-1:0] values,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_valid
);

  logic [DATA_W-1:0] sel_word;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  always_comb begin
    sel_word = '0;
    if (rd_op != OP_NONE) begin
      sel_word = values[rd_idx*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd_en;
      if (rd_en) begin
        data_q <= sel_word;
      end
    end
  end

  assign rd_data  = data_q;
  assign rd_valid = valid_q;

endmodule

// File: rtl/ipc_mailbox_bank.sv
module ipc_mailbox_bank
  import ipc_mbox_pkg::*;
#(
  parameter int unsigned N_CORES       = 4,
  parameter int unsigned MBOX_PER_CORE = 4,
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned SET_BASE      = 'h80,
  parameter int unsigned CLR_BASE      = 'hC0,
  parameter int unsigned N_MBOX        = N_CORES * MBOX_PER_CORE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wa_en,
  input  logic [ADDR_W-1:0] wa_addr,
  input  logic [DATA_W-1:0] wa_data,
  input  logic              wb_en,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [N_MBOX-1:0] mbox_pending
);

  localparam int unsigned IDX_W = $clog2(N_MBOX);

  mbox_op_e         a_op;
  mbox_op_e         b_op;
  mbox_op_e         r_op;
  logic [IDX_W-1:0] a_idx;
  logic [IDX_W-1:0] b_idx;
  logic [IDX_W-1:0] r_idx;

  logic [N_MBOX*DATA_W-1:0] values_flat;

  ipc_mbox_decode #(
    .ADDR_W(ADDR_W), .N_MBOX(N_MBOX), .SET_BASE(SET_BASE),
    .CLR_BASE(CLR_BASE), .IDX_W(IDX_W)
  ) i_dec_a (
    .en(wa_en), .addr(wa_addr), .op(a_op), .idx(a_idx)
  );

  ipc_mbox_decode #(
    .ADDR_W(ADDR_W), .N_MBOX(N_MBOX), .SET_BASE(SET_BASE),
    .CLR_BASE(CLR_BASE), .IDX_W(IDX_W)
  ) i_dec_b (
    .en(wb_en), .addr(wb_addr), .op(b_op), .idx(b_idx)
  );

  ipc_mbox_decode #(
    .ADDR_W(ADDR_W), .N_MBOX(N_MBOX), .SET_BASE(SET_BASE),
    .CLR_BASE(CLR_BASE), .IDX_W(IDX_W)
  ) i_dec_r (
    .en(rd_en), .addr(rd_addr), .op(r_op), .idx(r_idx)
  );

  for (genvar i = 0; i < N_MBOX; i++) begin : g_mbox
    logic              a_hit;
    logic              b_hit;
    logic [DATA_W-1:0] set_mask;
    logic [DATA_W-1:0] clr_mask;
    logic [DATA_W-1:0] value;
    logic              pending;

    always_comb begin
      a_hit    = (a_idx == IDX_W'(i));
      b_hit    = (b_idx == IDX_W'(i));
      set_mask = ({DATA_W{a_hit && (a_op == OP_SET)}} & wa_data)
               | ({DATA_W{b_hit && (b_op == OP_SET)}} & wb_data);
      clr_mask = ({DATA_W{a_hit && (a_op == OP_CLR)}} & wa_data)
               | ({DATA_W{b_hit && (b_op == OP_CLR)}} & wb_data);
    end

    ipc_mbox_cell #(.DATA_W(DATA_W)) i_cell (
      .clk(clk), .rst(rst), .set_mask(set_mask), .clr_mask(clr_mask),
      .value(value), .pending(pending)
    );

    assign values_flat[i*DATA_W +: DATA_W] = value;
    assign mbox_pending[i]                 = pending;
  end

  ipc_mbox_rdport #(
    .DATA_W(DATA_W), .N_MBOX(N_MBOX), .IDX_W(IDX_W)
  ) i_rdport (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_op(r_op), .rd_idx(r_idx),
    .values(values_flat), .rd_data(rd_data), .rd_valid(rd_valid)
  );

endmodule

// File: rtl/ipc_mailbox_bank_chk.sv
module ipc_mailbox_bank_chk #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned SET_BASE = 'h80,
  parameter int unsigned CLR_BASE = 'hC0,
  parameter int unsigned N_MBOX   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wa_en,
  input logic [ADDR_W-1:0] wa_addr,
  input logic [DATA_W-1:0] wa_data,
  input logic              wb_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic [N_MBOX-1:0] mbox_pending
);

  localparam int unsigned IDX_W = $clog2(N_MBOX);
  localparam int unsigned SPAN  = N_MBOX * 4;

  int unsigned      wa_u;
  int unsigned      rd_u;
  logic             a_in_set;
  logic             a_in_clr;
  logic             r_bad;
  logic [IDX_W-1:0] a_slot;

  always_comb begin
    wa_u     = int'(wa_addr);
    rd_u     = int'(rd_addr);
    a_in_set = (wa_addr[1:0] == 2'b00) && (wa_u >= SET_BASE) && (wa_u < SET_BASE + SPAN);
    a_in_clr = (wa_addr[1:0] == 2'b00) && (wa_u >= CLR_BASE) && (wa_u < CLR_BASE + SPAN);
    r_bad    = (rd_addr[1:0] != 2'b00)
            || !(((rd_u >= SET_BASE) && (rd_u < SET_BASE + SPAN))
              || ((rd_u >= CLR_BASE) && (rd_u < CLR_BASE + SPAN)));
    a_slot   = a_in_set ? IDX_W'((wa_u - SET_BASE) >> 2) : IDX_W'((wa_u - CLR_BASE) >> 2);
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (mbox_pending == '0) && !rd_valid); // R1

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (rst)
    (wa_en && a_in_set && (wa_data != '0) && !wb_en) |=> mbox_pending[$past(a_slot)]); // R2

  AST_FULL_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (wa_en && a_in_clr && (wa_data == '1) && !wb_en) |=> !mbox_pending[$past(a_slot)]); // R3

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R4

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid); // R4

  AST_PENDING_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!wa_en && !wb_en) |=> $stable(mbox_pending)); // R5

  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && r_bad) |=> (rd_data == '0)); // R7

endmodule

bind ipc_mailbox_bank ipc_mailbox_bank_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SET_BASE(SET_BASE),
  .CLR_BASE(CLR_BASE), .N_MBOX(N_MBOX)
) i_chk (
  .clk(clk), .rst(rst), .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
  .wb_en(wb_en), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .rd_valid(rd_valid), .mbox_pending(mbox_pending)
);

// File: tb/test_ipc_mailbox_bank.sv
`timescale 1ns/1ps
module test_ipc_mailbox_bank;

  localparam int NM = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        wa_en, wb_en, rd_en;
  logic [7:0]  wa_addr, wb_addr, rd_addr;
  logic [31:0] wa_data, wb_data;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [15:0] mbox_pending;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [31:0] mdl [NM];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  ipc_mailbox_bank i_ipc_mailbox_bank (
    .clk(clk), .rst(rst),
    .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .mbox_pending(mbox_pending)
  );

  // map an address to (window, slot); window 0 none, 1 set, 2 clear
  function automatic int win_of(input logic [7:0] a);
    if (a[1:0] != 2'b00) return 0;
    if (a >= 8'h80 && a < 8'hC0) return 1;
    if (a >= 8'hC0) return 2;
    return 0;
  endfunction

  function automatic int slot_of(input logic [7:0] a);
    return (win_of(a) == 1) ? (int'(a) - 'h80) / 4 : (int'(a) - 'hC0) / 4;
  endfunction

  function automatic logic [15:0] summary();
    logic [15:0] s;
    for (int i = 0; i < NM; i++) s[i] = (mdl[i] != 0);
    return s;
  endfunction

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected read results as the design returns them
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4 actual=unexpected rd_valid expected=no result");
      end else begin
        check32(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  // driver: one cycle of traffic, model update, summary check
  task automatic step(input logic ae, input logic [7:0] aa, input logic [31:0] ad,
                      input logic be, input logic [7:0] ba, input logic [31:0] bd,
                      input logic re, input logic [7:0] ra, input string tag);
    logic [31:0] s [NM];
    logic [31:0] c [NM];
    wa_en = ae; wa_addr = aa; wa_data = ad;
    wb_en = be; wb_addr = ba; wb_data = bd;
    rd_en = re; rd_addr = ra;
    if (re) begin
      exp_q.push_back(win_of(ra) == 0 ? 32'h0 : mdl[slot_of(ra)]);
      tag_q.push_back(tag);
    end
    for (int i = 0; i < NM; i++) begin s[i] = '0; c[i] = '0; end
    if (ae && win_of(aa) == 1) s[slot_of(aa)] |= ad;
    if (ae && win_of(aa) == 2) c[slot_of(aa)] |= ad;
    if (be && win_of(ba) == 1) s[slot_of(ba)] |= bd;
    if (be && win_of(ba) == 2) c[slot_of(ba)] |= bd;
    for (int i = 0; i < NM; i++) mdl[i] = (mdl[i] | s[i]) & ~c[i];
    @(posedge clk);
    @(negedge clk);
    check32({tag, " R5 pending"}, {16'h0, mbox_pending}, {16'h0, summary()});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    step(1, a, d, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    step(0, 0, 0, 0, 0, 0, 1, a, tag);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < NM; i++) rd(8'(8'hC0 + 4 * i), tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NM; i++) mdl[i] = '0;
    rst = 1'b1;
    wa_en = 0; wb_en = 0; rd_en = 0;
    wa_addr = 0; wb_addr = 0; rd_addr = 0; wa_data = 0; wb_data = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check32("R1 rd_valid", {31'h0, rd_valid}, 32'h0);
    check32("R1 pending", {16'h0, mbox_pending}, 32'h0);
    sweep("R1 reset contents");

    // R2: set window ORs; core1 mailbox2 = 0x98 / 0xD8
    wr(8'h98, 32'h0000_0005, "R2 set");
    rd(8'h98, "R4 read via set window");
    wr(8'h98, 32'h0000_0030, "R2 or-in");
    rd(8'hD8, "R2 or result");

    // R3 / R8: acknowledge lowest set bit one at a time
    wr(8'hD8, 32'h0000_0001, "R3 clear bit0");
    rd(8'hD8, "R3 partial clear");
    wr(8'hD8, 32'h0000_0004, "R8 ack bit2");
    wr(8'hD8, 32'h0000_0010, "R8 ack bit4");
    wr(8'hD8, 32'h0000_0020, "R8 ack bit5");
    rd(8'hD8, "R8 emptied");

    // R8: boot value into core2 mailbox3 (set 0xAC, clear 0xEC)
    wr(8'hAC, 32'hDEAD_BEEF, "R8 boot value");
    rd(8'hEC, "R8 boot readback");
    wr(8'hEC, 32'hFFFF_FFFF, "R3 full clear");

    // R6: collisions on core0 mailbox1 (0x84 / 0xC4)
    step(1, 8'h84, 32'h0000_FF00, 1, 8'hC4, 32'h0000_0F00, 0, 0, "R6 set vs clear");
    rd(8'hC4, "R6 clear wins");
    step(1, 8'h84, 32'h0000_0001, 1, 8'h84, 32'h0000_0002, 0, 0, "R6 two sets");
    rd(8'h84, "R6 sets combine");
    step(1, 8'hC4, 32'h0000_0001, 1, 8'h84, 32'h0000_0001, 0, 0, "R6 same bit");
    rd(8'h84, "R6 same-bit clear wins");

    // R4: read racing a write returns the old contents
    step(1, 8'h84, 32'h8000_0000, 0, 0, 0, 1, 8'h84, "R4 read-old");
    rd(8'h84, "R4 after write");

    // R7: stray and misaligned addresses
    wr(8'h7C, 32'hFFFF_FFFF, "R7 below window");
    wr(8'h82, 32'hFFFF_FFFF, "R7 misaligned set");
    wr(8'hC5, 32'hFFFF_FFFF, "R7 misaligned clear");
    wr(8'h00, 32'hFFFF_FFFF, "R7 zero addr");
    sweep("R7 untouched");
    rd(8'h40, "R7 bad read zero");
    rd(8'h86, "R7 misaligned read zero");

    // R2 / R5: every mailbox gets a distinct bit, then full clears
    for (int i = 0; i < NM; i++) wr(8'(8'h80 + 4 * i), 32'h1 << i, "R2 sweep set");
    sweep("R2 sweep contents");
    for (int i = 0; i < NM; i += 2) wr(8'(8'hC0 + 4 * i), 32'hFFFF_FFFF, "R3 sweep clear");
    sweep("R3 sweep contents");

    step(0, 0, 0, 0, 0, 0, 0, 0, "idle");
    check32("R4 outstanding reads", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule